// File: doc/BRIEF.md
# Up/Down/Center-Aligned Timer Counter

This block is the counting core of a general-purpose timer. A 16-bit counter steps once every (prescale + 1) input ticks. It can count upward and wrap, count downward and reload, or run as a triangle that turns at the reload value and at zero. The counter has a reload register, a prescale register and a compare register. Each register has a written value and an active value. The prescale and compare values always pass through this two-stage path. The reload value passes through it only when the reload-buffer control bit is set.

An update event copies the written values into the active ones. Three sources can raise an update event: a counter turn-around (overflow or underflow), a software update strobe, or an external reset request. Two control bits filter these sources. One bit suppresses the update event entirely. The other bit limits the sticky update flag to turn-arounds only. A single-shot bit makes the counter drop its own enable at the first update event. In triangle modes, a direction qualifier tells a compare unit whether a compare match may raise its flag in the current direction.

The block is driven by a control-write strobe that carries all control fields together. Separate write ports load the reload, prescale and compare values.

Top module: `updown_timer_core`

## Requirements
- R1: In mode 00 with the direction bit 0, each counter step adds 1. A step taken at a count equal to or above the active reload value wraps the count to 0, and that step is an overflow.
- R2: In mode 00 with the direction bit 1, each counter step subtracts 1. A step taken at a count of 0 reloads the active reload value, and that step is an underflow.
- R3: In modes 01, 10 and 11, the counter runs 0 up to the reload value (R) and back down to 0. Its period is 2·R steps. Reaching R turns the direction to down (`dir_o`=1), and reaching 0 turns it to up (`dir_o`=0). Each turn is a turn-around event.
- R4: `cmp_ok_o` is 1 in modes 00 and 11, 1 only while counting down in mode 01, and 1 only while counting up in mode 10. `cmp_hit_o` is 1 when the count equals the active compare value and `cmp_ok_o` is 1.
- R5: While enabled, the counter takes one step per (P + 1) cycles in which `tick_i` is 1, where P is the active prescale value. With `tick_i` low, the counter holds.
- R6: With `ctl_arr_buf_i`=0, a reload write reaches `reload_o` on the next cycle. With `ctl_arr_buf_i`=1, the write reaches `reload_o` only at an update event.
- R7: Prescale and compare writes reach `pre_o` and `cmp_o` only at an update event.
- R8: With `ctl_single_i`=1, the enable bit (`en_o`) drops at the first update event, and the count then holds.
- R9: With `ctl_upd_off_i`=1, no update event occurs and the active values keep their contents. A software update strobe or an external reset still restarts the counter and the prescaler.
- R10: With `ctl_ovf_only_i`=0, every update event sets `upd_flag_o`. With `ctl_ovf_only_i`=1, only a turn-around sets `upd_flag_o`, while the strobe and the external reset still give an update event.
- R11: `sw_upd_i` or `ext_rst_i` restarts the count: to 0 when the direction is up, or to the reload value when the direction is down. The restart also clears the prescaler, so the next step comes P + 1 ticks later.
- R12: In modes 01, 10 and 11, control writes leave the direction unchanged. While the counter is enabled in mode 00, a write that asks for mode 01, 10 or 11 keeps mode 00.
- R13: `upd_evt_o` is high for one cycle, in the cycle after the event. `upd_flag_o` stays set until `upd_flag_clr_i` is pulsed.
- R14: After reset, the count, direction, enable, flag, event and all active values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable tick into the prescaler |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_mode_i | input | 2 | Counting mode (00 edge, 01/10/11 center) |
| ctl_dir_i | input | 1 | Direction for edge mode (1 = down) |
| ctl_en_i | input | 1 | Counter enable |
| ctl_single_i | input | 1 | Stop at the next update event |
| ctl_ovf_only_i | input | 1 | Flag set only by turn-arounds |
| ctl_upd_off_i | input | 1 | Suppress update events |
| ctl_arr_buf_i | input | 1 | Buffer reload writes until an update |
| reload_wr_i | input | 1 | Reload value write strobe |
| reload_wdata_i | input | 16 | Reload value |
| pre_wr_i | input | 1 | Prescale write strobe |
| pre_wdata_i | input | 16 | Prescale value |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 16 | Compare value |
| sw_upd_i | input | 1 | Software update strobe (one cycle) |
| ext_rst_i | input | 1 | External reset/update request |
| upd_flag_clr_i | input | 1 | Clears the update flag |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | Current direction (1 = down) |
| en_o | output | 1 | Enable state |
| reload_o | output | 16 | Active reload value |
| pre_o | output | 16 | Active prescale value |
| cmp_o | output | 16 | Active compare value |
| upd_evt_o | output | 1 | Update event pulse |
| upd_flag_o | output | 1 | Sticky update flag |
| cmp_ok_o | output | 1 | Compare flags allowed in this direction |
| cmp_hit_o | output | 1 | Qualified compare match |

## Verification
The counting function is swept over every mode (up, down and the three triangle modes), with reload values from 0 to 5 and prescale values from 0 to 2. At every cycle, the count, direction, event pulse and compare qualifier are checked against a closed-form position in the up ramp, the down ramp or the triangle. These sweeps separate an off-by-one at a turn, a wrong period, and a prescaler that steps too early. Directed sequences then cover the event filters (update suppressed, flag limited to turn-arounds), the two reload paths, single-shot stop, a restart in mid-count by an external request, a tick held low, and the two ignored control writes. The ignored writes are checked through the count and the direction they would have changed.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;

  typedef enum logic [1:0] {
    MODE_EDGE     = 2'b00,
    MODE_CTR_DN   = 2'b01,
    MODE_CTR_UP   = 2'b10,
    MODE_CTR_BOTH = 2'b11
  } tmr_mode_e;

  // Compare flags may be raised in this direction (dn = 1 means counting down).
  function automatic logic cmp_qualify(tmr_mode_e m, logic dn);
    case (m)
      MODE_CTR_DN: return dn;
      MODE_CTR_UP: return !dn;
      default:     return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/updown_timer_shadow.sv
module updown_timer_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         direct_i,
  input  logic         load_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] nx_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] act_q;
  logic         direct_wr;

  assign direct_wr = wr_i && direct_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_i) pend_q <= wdata_i;
      if (direct_wr)   act_q <= wdata_i;
      else if (load_i) act_q <= pend_q;
    end
  end

  always_comb begin
    if (direct_wr)   nx_o = wdata_i;
    else if (load_i) nx_o = pend_q;
    else             nx_o = act_q;
  end

  assign act_o = act_q;

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !direct_wr) |=> $stable(act_o));

endmodule

// File: rtl/updown_timer_prescaler.sv
module updown_timer_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] lim_i,
  output logic             step_o
);
  logic [PRE_W-1:0] div_q;
  logic             at_lim;

  assign at_lim = (div_q >= lim_i);
  assign step_o = run_i && at_lim && !clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (run_i)  div_q <= at_lim ? '0 : div_q + PRE_W'(1);
  end

  // R5
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(div_q));

  // R11
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (div_q == '0));

endmodule

// File: rtl/updown_timer_count.sv
module updown_timer_count
  import updown_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             reinit_i,
  input  tmr_mode_e        mode_i,
  input  logic             dir_ld_i,
  input  logic             dir_val_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] top_reinit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             wrap_o
);
  localparam int VEC_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic [VEC_W-1:0] nxt;

  // Returns {turn_event, next_dir, next_count}.
  function automatic logic [VEC_W-1:0] next_state(tmr_mode_e m, logic dn,
                                                  logic [CNT_W-1:0] c,
                                                  logic [CNT_W-1:0] t);
    logic [CNT_W-1:0] n;
    logic             d;
    logic             e;
    d = dn;
    e = 1'b0;
    if (m == MODE_EDGE) begin
      if (!dn) begin
        if (c >= t) begin n = '0; e = 1'b1; end
        else          n = c + CNT_W'(1);
      end else begin
        if (c == '0) begin n = t; e = 1'b1; end
        else           n = c - CNT_W'(1);
      end
    end else begin
      if (!dn) begin
        if (c >= t) begin
          n = t; d = 1'b1; e = 1'b1;
        end else begin
          n = c + CNT_W'(1);
          if (n == t) begin d = 1'b1; e = 1'b1; end
        end
      end else begin
        if (c == '0) begin
          n = '0; d = 1'b0; e = 1'b1;
        end else begin
          n = c - CNT_W'(1);
          if (n == '0) begin d = 1'b0; e = 1'b1; end
        end
      end
    end
    return {e, d, n};
  endfunction

  always_comb nxt = next_state(mode_i, dir_q, cnt_q, top_i);

  assign wrap_o = step_i && !reinit_i && nxt[CNT_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      if (reinit_i)    cnt_q <= dir_q ? top_reinit_i : '0;
      else if (step_i) cnt_q <= nxt[CNT_W-1:0];
      if (dir_ld_i)
        dir_q <= dir_val_i;
      else if (step_i && !reinit_i && mode_i != MODE_EDGE)
        dir_q <= nxt[CNT_W];
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  // R1
  edge_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !reinit_i && mode_i == MODE_EDGE && !dir_q && cnt_q >= top_i)
      |=> (cnt_q == '0));

  // R2
  edge_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !reinit_i && mode_i == MODE_EDGE && dir_q && cnt_q == '0)
      |=> (cnt_q == $past(top_i)));

  // R3
  ctr_turn_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !reinit_i && !dir_ld_i && mode_i != MODE_EDGE && !dir_q &&
     ({1'b0, cnt_q} + 1'b1 == {1'b0, top_i})) |=> dir_q);

  // R12
  dir_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_EDGE && !dir_ld_i && !step_i) |=> $stable(dir_q));

endmodule

// File: rtl/updown_timer_ctl.sv
module updown_timer_ctl
  import updown_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [1:0] mode_i,
  input  logic       dir_i,
  input  logic       en_i,
  input  logic       single_i,
  input  logic       ovf_only_i,
  input  logic       upd_off_i,
  input  logic       arr_buf_i,
  input  logic       upd_evt_i,
  output tmr_mode_e  mode_o,
  output logic       en_o,
  output logic       single_o,
  output logic       ovf_only_o,
  output logic       upd_off_o,
  output logic       arr_buf_o,
  output logic       dir_ld_o,
  output logic       dir_val_o
);
  tmr_mode_e mode_q, mode_nx;
  logic      en_q, single_q, ovf_only_q, upd_off_q, arr_buf_q;
  logic      blocked;

  // Edge -> center while running is refused; the mode stays edge.
  assign blocked = en_q && (mode_q == MODE_EDGE) && (mode_i != 2'b00);

  always_comb begin
    mode_nx = mode_q;
    if (wr_i && !blocked) mode_nx = tmr_mode_e'(mode_i);
  end

  assign dir_ld_o  = wr_i && (mode_nx == MODE_EDGE);
  assign dir_val_o = dir_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_EDGE;
      en_q       <= 1'b0;
      single_q   <= 1'b0;
      ovf_only_q <= 1'b0;
      upd_off_q  <= 1'b0;
      arr_buf_q  <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      if (wr_i) begin
        single_q   <= single_i;
        ovf_only_q <= ovf_only_i;
        upd_off_q  <= upd_off_i;
        arr_buf_q  <= arr_buf_i;
      end
      if (single_q && upd_evt_i) en_q <= 1'b0;
      else if (wr_i)             en_q <= en_i;
    end
  end

  assign mode_o     = mode_q;
  assign en_o       = en_q;
  assign single_o   = single_q;
  assign ovf_only_o = ovf_only_q;
  assign upd_off_o  = upd_off_q;
  assign arr_buf_o  = arr_buf_q;

  // R8
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_q && upd_evt_i) |=> !en_q);

  // R12
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && en_q && mode_q == MODE_EDGE) |=> (mode_q == MODE_EDGE));

endmodule

// File: rtl/updown_timer_core.sv
module updown_timer_core
  import updown_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ctl_wr_i,
  input  logic [1:0]       ctl_mode_i,
  input  logic             ctl_dir_i,
  input  logic             ctl_en_i,
  input  logic             ctl_single_i,
  input  logic             ctl_ovf_only_i,
  input  logic             ctl_upd_off_i,
  input  logic             ctl_arr_buf_i,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] reload_wdata_i,
  input  logic             pre_wr_i,
  input  logic [PRE_W-1:0] pre_wdata_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             sw_upd_i,
  input  logic             ext_rst_i,
  input  logic             upd_flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             en_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             upd_evt_o,
  output logic             upd_flag_o,
  output logic             cmp_ok_o,
  output logic             cmp_hit_o
);
  tmr_mode_e        mode;
  logic             en, single, ovf_only, upd_off, arr_buf;
  logic             dir_ld, dir_val;
  logic             step, wrap, reinit, upd_req, upd_now, flag_set;
  logic [CNT_W-1:0] top_act, top_nx, cmp_act, cmp_nx_unused;
  logic [PRE_W-1:0] pre_act, pre_nx_unused;
  logic             upd_evt_q, flag_q;

  assign reinit   = sw_upd_i || ext_rst_i;
  assign upd_req  = wrap || reinit;
  assign upd_now  = upd_req && !upd_off;
  assign flag_set = !upd_off && (ovf_only ? wrap : upd_req);

  updown_timer_ctl u_ctl (
    .clk, .rst_n,
    .wr_i(ctl_wr_i), .mode_i(ctl_mode_i), .dir_i(ctl_dir_i), .en_i(ctl_en_i),
    .single_i(ctl_single_i), .ovf_only_i(ctl_ovf_only_i),
    .upd_off_i(ctl_upd_off_i), .arr_buf_i(ctl_arr_buf_i),
    .upd_evt_i(upd_now),
    .mode_o(mode), .en_o(en), .single_o(single), .ovf_only_o(ovf_only),
    .upd_off_o(upd_off), .arr_buf_o(arr_buf),
    .dir_ld_o(dir_ld), .dir_val_o(dir_val)
  );

  updown_timer_shadow #(.W(CNT_W)) u_top_sh (
    .clk, .rst_n, .wr_i(reload_wr_i), .wdata_i(reload_wdata_i),
    .direct_i(!arr_buf), .load_i(upd_now), .act_o(top_act), .nx_o(top_nx)
  );

  updown_timer_shadow #(.W(PRE_W)) u_pre_sh (
    .clk, .rst_n, .wr_i(pre_wr_i), .wdata_i(pre_wdata_i),
    .direct_i(1'b0), .load_i(upd_now), .act_o(pre_act), .nx_o(pre_nx_unused)
  );

  updown_timer_shadow #(.W(CNT_W)) u_cmp_sh (
    .clk, .rst_n, .wr_i(cmp_wr_i), .wdata_i(cmp_wdata_i),
    .direct_i(1'b0), .load_i(upd_now), .act_o(cmp_act), .nx_o(cmp_nx_unused)
  );

  updown_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk, .rst_n, .run_i(en && tick_i), .clr_i(reinit),
    .lim_i(pre_act), .step_o(step)
  );

  updown_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .step_i(step), .reinit_i(reinit), .mode_i(mode),
    .dir_ld_i(dir_ld), .dir_val_i(dir_val),
    .top_i(top_act), .top_reinit_i(top_nx),
    .cnt_o(cnt_o), .dir_o(dir_o), .wrap_o(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_evt_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      upd_evt_q <= upd_now;
      if (flag_set)            flag_q <= 1'b1;
      else if (upd_flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign en_o       = en;
  assign reload_o   = top_act;
  assign pre_o      = pre_act;
  assign cmp_o      = cmp_act;
  assign upd_evt_o  = upd_evt_q;
  assign upd_flag_o = flag_q;
  assign cmp_ok_o   = cmp_qualify(mode, dir_o);
  assign cmp_hit_o  = cmp_ok_o && (cnt_o == cmp_act);

  // R9
  upd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off |=> !upd_evt_o);

  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_flag_o) |-> upd_evt_o);

  // R13
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_flag_o && !upd_flag_clr_i) |=> upd_flag_o);

endmodule

// File: tb/sim_updown_timer_core.sv
`timescale 1ns/1ps
module sim_updown_timer_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b1;
  logic        ctl_wr_i = 0, ctl_dir_i = 0, ctl_en_i = 0, ctl_single_i = 0;
  logic        ctl_ovf_only_i = 0, ctl_upd_off_i = 0, ctl_arr_buf_i = 0;
  logic [1:0]  ctl_mode_i = 2'b00;
  logic        reload_wr_i = 0, pre_wr_i = 0, cmp_wr_i = 0;
  logic [15:0] reload_wdata_i = 0, pre_wdata_i = 0, cmp_wdata_i = 0;
  logic        sw_upd_i = 0, ext_rst_i = 0, upd_flag_clr_i = 0;
  logic [15:0] cnt_o, reload_o, pre_o, cmp_o;
  logic        dir_o, en_o, upd_evt_o, upd_flag_o, cmp_ok_o, cmp_hit_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  updown_timer_core u0 (.*);

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ctl_write(int mode, bit dn, bit en, bit single, bit ovf_only,
                           bit upd_off, bit arr_buf);
    @(negedge clk);
    ctl_wr_i = 1; ctl_mode_i = 2'(mode); ctl_dir_i = dn; ctl_en_i = en;
    ctl_single_i = single; ctl_ovf_only_i = ovf_only;
    ctl_upd_off_i = upd_off; ctl_arr_buf_i = arr_buf;
    @(negedge clk);
    ctl_wr_i = 0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); sw_upd_i = 1;
    @(negedge clk); sw_upd_i = 0;
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_rst_i = 1;
    @(negedge clk); ext_rst_i = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); upd_flag_clr_i = 1;
    @(negedge clk); upd_flag_clr_i = 0;
  endtask

  task automatic write_vals(bit wr_top, int top, bit wr_pre, int pre, bit wr_cmp, int cmpv);
    @(negedge clk);
    reload_wr_i = wr_top; reload_wdata_i = 16'(top);
    pre_wr_i = wr_pre; pre_wdata_i = 16'(pre);
    cmp_wr_i = wr_cmp; cmp_wdata_i = 16'(cmpv);
    @(negedge clk);
    reload_wr_i = 0; pre_wr_i = 0; cmp_wr_i = 0;
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  // Disabled, loaded and restarted: up modes sit at 0, edge-down sits at top.
  task automatic prep(int mode, bit dn, int top, int pre, int cmpv);
    ctl_write(0, dn, 0, 0, 0, 0, 0);
    if (mode != 0) ctl_write(mode, 0, 0, 0, 0, 0, 0);
    write_vals(1, top, 1, pre, 1, cmpv);
    pulse_upd();
    pulse_clr();
  endtask

  function automatic int exp_cnt(int mode, bit dn, int a, int s);
    int t;
    if (mode == 0) return dn ? a - (s % (a + 1)) : s % (a + 1);
    t = s % (2 * a);
    return (t <= a) ? t : 2 * a - t;
  endfunction

  function automatic bit exp_turn(int mode, int a, int s);
    if (s == 0) return 0;
    if (mode == 0) return (s % (a + 1)) == 0;
    return (s % a) == 0;
  endfunction

  function automatic bit exp_dir(int mode, bit dn, int a, int s);
    if (mode == 0) return dn;
    return (s % (2 * a)) >= a;
  endfunction

  function automatic bit exp_ok(int mode, bit d);
    if (mode == 1) return d;
    if (mode == 2) return !d;
    return 1;
  endfunction

  task automatic sweep(int mode, bit dn, int a, int p);
    int n_cyc;
    n_cyc = (mode == 0) ? 2 * (a + 1) * (p + 1) + 2 : 4 * a * (p + 1) + 2;
    prep(mode, dn, a, p, 1);
    ctl_write(mode, dn, 1, 0, 0, 0, 0);
    for (int n = 1; n <= n_cyc; n++) begin
      int s, c;
      bit d;
      edge1();
      s = n / (p + 1);
      c = exp_cnt(mode, dn, a, s);
      d = exp_dir(mode, dn, a, s);
      // R1 R2 R3 R5: count position
      chk(mode == 0 ? (dn ? "R2" : "R1") : "R3", int'(cnt_o), c);
      // R5 R13: event pulse only on the step that turns
      chk("R5", int'(upd_evt_o), int'((n % (p + 1)) == 0 && exp_turn(mode, a, s)));
      chk("R3", int'(dir_o), int'(d));
      // R4
      chk("R4", int'(cmp_ok_o), int'(exp_ok(mode, d)));
      chk("R4", int'(cmp_hit_o), int'(exp_ok(mode, d) && c == 1));
    end
    ctl_write(mode, dn, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    edge1();
    // R14
    chk("R14", int'(cnt_o), 0);
    chk("R14", int'(dir_o), 0);
    chk("R14", int'(en_o), 0);
    chk("R14", int'(upd_flag_o), 0);
    chk("R14", int'(upd_evt_o), 0);
    chk("R14", int'(reload_o) + int'(pre_o) + int'(cmp_o), 0);

    for (int a = 0; a <= 5; a++)
      for (int p = 0; p <= 2; p++) begin
        sweep(0, 0, a, p);
        sweep(0, 1, a, p);
        if (a > 0)
          for (int m = 1; m <= 3; m++) sweep(m, 0, a, p);
      end

    // R6: buffered reload waits for an update, direct reload lands at once
    prep(0, 0, 3, 0, 1);
    ctl_write(0, 0, 0, 0, 0, 0, 1);
    write_vals(1, 7, 0, 0, 0, 0);
    chk("R6", int'(reload_o), 3);
    pulse_upd();
    chk("R6", int'(reload_o), 7);
    ctl_write(0, 0, 0, 0, 0, 0, 0);
    write_vals(1, 5, 0, 0, 0, 0);
    chk("R6", int'(reload_o), 5);

    // R7: prescale and compare wait for an update (external request here)
    write_vals(0, 0, 1, 2, 1, 4);
    chk("R7", int'(pre_o), 0);
    chk("R7", int'(cmp_o), 1);
    pulse_ext();
    chk("R7", int'(pre_o), 2);
    chk("R7", int'(cmp_o), 4);
    chk("R13", int'(upd_evt_o), 1);
    chk("R10", int'(upd_flag_o), 1);
    edge1();
    chk("R13", int'(upd_evt_o), 0);
    pulse_clr();

    // R9: suppressed updates; restart still happens
    prep(0, 1, 4, 0, 1);
    chk("R11", int'(cnt_o), 4);
    ctl_write(0, 0, 0, 0, 0, 1, 0);
    write_vals(0, 0, 0, 0, 1, 6);
    pulse_upd();
    chk("R9", int'(cnt_o), 0);
    chk("R9", int'(upd_evt_o), 0);
    chk("R9", int'(upd_flag_o), 0);
    chk("R9", int'(cmp_o), 1);
    ctl_write(0, 0, 1, 0, 0, 1, 0);
    for (int n = 1; n <= 6; n++) begin
      edge1();
      chk("R9", int'(upd_evt_o), 0);
    end
    chk("R9", int'(cnt_o), 1);
    chk("R9", int'(upd_flag_o), 0);
    ctl_write(0, 0, 0, 0, 0, 0, 0);

    // R10 R13: flag only on turn-around when limited
    prep(0, 0, 2, 0, 1);
    ctl_write(0, 0, 0, 0, 1, 0, 0);
    pulse_upd();
    chk("R10", int'(upd_evt_o), 1);
    chk("R10", int'(upd_flag_o), 0);
    pulse_ext();
    chk("R10", int'(upd_evt_o), 1);
    chk("R10", int'(upd_flag_o), 0);
    ctl_write(0, 0, 1, 0, 1, 0, 0);
    edge1(); edge1(); edge1();
    chk("R1", int'(cnt_o), 0);
    chk("R10", int'(upd_flag_o), 1);
    edge1();
    chk("R13", int'(upd_evt_o), 0);
    chk("R13", int'(upd_flag_o), 1);
    ctl_write(0, 0, 0, 0, 1, 0, 0);
    chk("R13", int'(cnt_o), 2);
    pulse_clr();
    chk("R13", int'(upd_flag_o), 0);

    // R11 R5: external restart mid-count in down mode clears the prescaler
    prep(0, 1, 6, 1, 1);
    ctl_write(0, 1, 1, 0, 0, 0, 0);
    edge1(); edge1(); edge1(); edge1();
    chk("R2", int'(cnt_o), 4);
    @(negedge clk); ext_rst_i = 1;
    edge1();
    chk("R11", int'(cnt_o), 6);
    @(negedge clk); ext_rst_i = 0;
    edge1();
    chk("R11", int'(cnt_o), 6);
    edge1();
    chk("R11", int'(cnt_o), 5);
    ctl_write(0, 1, 0, 0, 0, 0, 0);

    // R5: tick held low freezes the count
    prep(0, 0, 5, 0, 1);
    ctl_write(0, 0, 1, 0, 0, 0, 0);
    edge1();
    chk("R5", int'(cnt_o), 1);
    @(negedge clk); tick_i = 0;
    edge1(); edge1(); edge1();
    chk("R5", int'(cnt_o), 1);
    @(negedge clk); tick_i = 1;
    edge1();
    chk("R5", int'(cnt_o), 2);
    ctl_write(0, 0, 0, 0, 0, 0, 0);

    // R8: single shot
    prep(0, 0, 2, 0, 1);
    ctl_write(0, 0, 1, 1, 0, 0, 0);
    edge1(); edge1();
    chk("R8", int'(cnt_o), 2);
    chk("R8", int'(en_o), 1);
    edge1();
    chk("R8", int'(cnt_o), 0);
    chk("R8", int'(en_o), 0);
    chk("R8", int'(upd_evt_o), 1);
    edge1(); edge1();
    chk("R8", int'(cnt_o), 0);

    // R12: edge -> center refused while running
    prep(0, 0, 3, 0, 1);
    ctl_write(0, 0, 1, 0, 0, 0, 0);
    edge1();
    chk("R12", int'(cnt_o), 1);
    ctl_write(3, 0, 1, 0, 0, 0, 0);
    chk("R12", int'(cnt_o), 2);
    edge1();
    chk("R12", int'(cnt_o), 3);
    edge1();
    chk("R12", int'(cnt_o), 0);
    ctl_write(0, 0, 0, 0, 0, 0, 0);

    // R12: direction bit ignored in center mode
    prep(3, 0, 4, 0, 1);
    ctl_write(3, 0, 1, 0, 0, 0, 0);
    edge1();
    chk("R3", int'(cnt_o), 1);
    ctl_write(3, 1, 1, 0, 0, 0, 0);
    chk("R12", int'(dir_o), 0);
    edge1();
    chk("R12", int'(cnt_o), 3);
    chk("R12", int'(dir_o), 0);
    ctl_write(3, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule